// File: doc/BRIEF.md
# Set-Compare and Conditional-Move Unit

This execution unit produces the register result for two families of instructions. The first family is the set-on-compare operations. Each one compares two operands and turns the outcome into a register value of 0 or 1. The second operand comes either from a second register or from a 16-bit immediate field, selected by a flag. The second family is the conditional moves. A conditional move copies one register into the destination, but only when a second register tests zero (or nonzero, depending on the operation). When a move is not taken, the unit tells the register file to skip the write.

The unit has one clock of latency. Every input set presented before a rising edge produces a registered result and a write-enable on that edge. The current destination value is an input, so the result port always holds a defined value, even when no write happens. The unit does not cover general arithmetic, the register file or forwarding.

Top module: `scmv_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `result` becomes 0 and `wr_en` becomes 0 on that edge.
- R2: `result` and `wr_en` update on the first rising edge after the inputs are applied, and stay stable between edges.
- R3: Operation codes: 0 set-equal, 1 set-not-equal. The result is 1 when the condition holds and 0 otherwise, zero-extended to 32 bits.
- R4: Codes 2 (less), 4 (greater), 6 (less-or-equal) and 8 (greater-or-equal) compare the operands as two's-complement signed values.
- R5: Codes 3, 5, 7 and 9 perform the same four relations in that order, with the operands compared as unsigned values.
- R6: When `use_imm` is 1, the second compare operand is `imm` sign-extended from bit 15 to 32 bits. When `use_imm` is 0, it is `src_b`.
- R7: Code 10 (move-on-zero) depends on `src_b`. If `src_b` is 0, `result` is `src_a` and `wr_en` is 1. Otherwise `wr_en` is 0 and `result` is `dst_old`.
- R8: Code 11 (move-on-nonzero) depends on `src_b`. If `src_b` is nonzero, `result` is `src_a` and `wr_en` is 1. Otherwise `wr_en` is 0 and `result` is `dst_old`.
- R9: Every compare operation (codes 0 to 9) asserts `wr_en`.
- R10: Codes 12 to 15 are undefined. For these codes `wr_en` is 0 and `result` is `dst_old`.
- R11: For the conditional moves, `use_imm` and `imm` have no effect. The test always uses `src_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code |
| src_a | input | 32 | First register operand; the value copied by a move |
| src_b | input | 32 | Second register operand; the zero-test value for moves |
| imm | input | 16 | Immediate field, sign-extended for compares |
| use_imm | input | 1 | 1 selects the immediate as the second compare operand |
| dst_old | input | 32 | Current contents of the destination register |
| result | output | 32 | Registered result value |
| wr_en | output | 1 | Registered destination write-enable |

## Verification
The unit holds no state beyond its output registers, so any fault shows at the ports on the edge right after the stimulus. A swapped signed and unsigned decode shows only when the operands differ in their top bit, so the tests pair negative values with small positive ones. An inverted move condition or a stuck write-enable shows within one cycle in the value of `wr_en`. A faulty immediate extension shows only with immediates whose bit 15 is set.

// File: rtl/scmv_pkg.sv
package scmv_pkg;
  localparam int DATA_W = 32;
  localparam int IMM_W  = 16;
  localparam int OP_W   = 4;

  localparam logic [OP_W-1:0] OP_SEQ  = 4'd0;
  localparam logic [OP_W-1:0] OP_SNE  = 4'd1;
  localparam logic [OP_W-1:0] OP_SLT  = 4'd2;
  localparam logic [OP_W-1:0] OP_SLTU = 4'd3;
  localparam logic [OP_W-1:0] OP_SGT  = 4'd4;
  localparam logic [OP_W-1:0] OP_SGTU = 4'd5;
  localparam logic [OP_W-1:0] OP_SLE  = 4'd6;
  localparam logic [OP_W-1:0] OP_SLEU = 4'd7;
  localparam logic [OP_W-1:0] OP_SGE  = 4'd8;
  localparam logic [OP_W-1:0] OP_SGEU = 4'd9;
  localparam logic [OP_W-1:0] OP_MOVZ = 4'd10;
  localparam logic [OP_W-1:0] OP_MOVN = 4'd11;

  function automatic logic op_is_cmp(input logic [OP_W-1:0] o);
    return o <= OP_SGEU;
  endfunction
endpackage

// File: rtl/scmv_operand.sv
module scmv_operand #(
  parameter int DW = 32,
  parameter int IW = 16
) (
  input  logic [DW-1:0] reg_b,
  input  logic [IW-1:0] imm,
  input  logic          use_imm,
  output logic [DW-1:0] opnd_b
);
  localparam int EXT_W = DW - IW;
  logic [DW-1:0] imm_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign imm_ext = {{EXT_W{imm[IW-1]}}, imm};
    end else begin : g_trunc
      assign imm_ext = imm[DW-1:0];
    end
  endgenerate

  assign opnd_b = use_imm ? imm_ext : reg_b;
endmodule

// File: rtl/scmv_compare.sv
module scmv_compare
  import scmv_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [OP_W-1:0] op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  output logic            hit
);
  logic eq, lt_s, gt_s, lt_u, gt_u;

  assign eq   = (a == b);
  assign lt_u = (a < b);
  assign gt_u = (b < a);
  assign lt_s = ($signed(a) < $signed(b));
  assign gt_s = ($signed(b) < $signed(a));

  always_comb begin
    unique case (op)
      OP_SEQ:  hit = eq;
      OP_SNE:  hit = !eq;
      OP_SLT:  hit = lt_s;
      OP_SLTU: hit = lt_u;
      OP_SGT:  hit = gt_s;
      OP_SGTU: hit = gt_u;
      OP_SLE:  hit = !gt_s;
      OP_SLEU: hit = !gt_u;
      OP_SGE:  hit = !lt_s;
      OP_SGEU: hit = !lt_u;
      default: hit = 1'b0;
    endcase
  end

  // R4 / R5: each ordering picks exactly one of less, equal, greater
  always_comb begin
    a_r4_signed_order: assert ($onehot({lt_s, eq, gt_s}))
      else $error("signed ordering not exclusive");
    a_r5_unsigned_order: assert ($onehot({lt_u, eq, gt_u}))
      else $error("unsigned ordering not exclusive");
  end
endmodule

// File: rtl/scmv_move.sv
module scmv_move
  import scmv_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [OP_W-1:0] op,
  input  logic [DW-1:0]   test,
  output logic            take
);
  logic is_zero;
  assign is_zero = (test == '0);

  always_comb begin
    case (op)
      OP_MOVZ: take = is_zero;
      OP_MOVN: take = !is_zero;
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/scmv_unit.sv
module scmv_unit
  import scmv_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IMM_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] op,
  input  logic [DW-1:0]   src_a,
  input  logic [DW-1:0]   src_b,
  input  logic [IW-1:0]   imm,
  input  logic            use_imm,
  input  logic [DW-1:0]   dst_old,
  output logic [DW-1:0]   result,
  output logic            wr_en
);
  logic [DW-1:0] opnd_b;
  logic          cmp_hit;
  logic          mv_take;
  logic          is_cmp;
  logic [DW-1:0] res_d;
  logic          we_d;
  logic [DW-1:0] res_q;
  logic          we_q;
  logic          live_q;

  scmv_operand #(.DW(DW), .IW(IW)) u_opnd (
    .reg_b(src_b), .imm(imm), .use_imm(use_imm), .opnd_b(opnd_b)
  );

  scmv_compare #(.DW(DW)) u_cmp (
    .op(op), .a(src_a), .b(opnd_b), .hit(cmp_hit)
  );

  scmv_move #(.DW(DW)) u_mv (
    .op(op), .test(src_b), .take(mv_take)
  );

  assign is_cmp = op_is_cmp(op);

  always_comb begin
    if (is_cmp) begin
      res_d = {{(DW-1){1'b0}}, cmp_hit};
      we_d  = 1'b1;
    end else if (mv_take) begin
      res_d = src_a;
      we_d  = 1'b1;
    end else begin
      res_d = dst_old;
      we_d  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      we_q   <= 1'b0;
      live_q <= 1'b0;
    end else begin
      res_q  <= res_d;
      we_q   <= we_d;
      live_q <= 1'b1;
    end
  end

  assign result = res_q;
  assign wr_en  = we_q;

  // R9: compares always write
  a_r9_cmp_writes: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(op_is_cmp(op))) |-> wr_en)
    else $error("compare without write-enable");

  // R3: compare results are zero-extended booleans
  a_r3_zero_ext: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(op_is_cmp(op))) |-> (result[DW-1:1] == '0))
    else $error("compare result not 0/1");

  // R7 / R8 / R10: a suppressed write carries the old destination value
  a_r7_hold_old: assert property (@(posedge clk) disable iff (rst)
    (live_q && !wr_en) |-> (result == $past(dst_old)))
    else $error("suppressed write changed value");

  // R10: undefined codes never write
  a_r10_undef_nowrite: assert property (@(posedge clk) disable iff (rst)
    (live_q && ($past(op) > OP_MOVN)) |-> !wr_en)
    else $error("undefined code wrote");

  // R1: reset clears outputs on the next edge
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (result == '0 && !wr_en))
    else $error("reset did not clear");
endmodule

// File: tb/scmv_unit_test.sv
module scmv_unit_test;
  import scmv_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op = '0;
  logic [31:0] src_a = '0, src_b = '0, dst_old = '0;
  logic [15:0] imm = '0;
  logic        use_imm = 1'b0;
  logic [31:0] result;
  logic        wr_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  scmv_unit uut (
    .clk(clk), .rst(rst), .op(op), .src_a(src_a), .src_b(src_b),
    .imm(imm), .use_imm(use_imm), .dst_old(dst_old),
    .result(result), .wr_en(wr_en)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] sext(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic rel(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b);
    logic signed [31:0] sa, sb;
    sa = a; sb = b;
    case (o)
      4'd0: return a == b;
      4'd1: return a != b;
      4'd2: return sa < sb;
      4'd3: return a < b;
      4'd4: return sa > sb;
      4'd5: return a > b;
      4'd6: return sa <= sb;
      4'd7: return a <= b;
      4'd8: return sa >= sb;
      4'd9: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got_r, input logic got_w,
                       input logic [31:0] exp_r, input logic exp_w);
    n_tests++;
    if (got_r !== exp_r || got_w !== exp_w) begin
      n_fail++;
      $display("FAIL %s: result=%h wr_en=%b expected result=%h wr_en=%b",
               req, got_r, got_w, exp_r, exp_w);
    end
  endtask

  // drive at negedge, sample one negedge later (one register on the path)
  task automatic apply(input string req, input logic [3:0] o, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] im, input logic ui,
                       input logic [31:0] d, input logic [31:0] exp_r, input logic exp_w);
    op = o; src_a = a; src_b = b; imm = im; use_imm = ui; dst_old = d;
    @(negedge clk);
    check(req, result, wr_en, exp_r, exp_w);
  endtask

  task automatic cmp(input string req, input logic [3:0] o, input logic [31:0] a,
                     input logic [31:0] b);
    apply(req, o, a, b, 16'h0, 1'b0, 32'hDEAD_BEEF, {31'b0, rel(o, a, b)}, 1'b1);
  endtask

  task automatic t_reset;
    apply("R3", 4'd0, 32'd5, 32'd5, 16'h0, 1'b0, 32'h0, 32'd1, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check("R1", result, wr_en, 32'h0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_latency;
    apply("R2", 4'd10, 32'h1234_5678, 32'h0, 16'h0, 1'b0, 32'h0, 32'h1234_5678, 1'b1);
    op = 4'd11; src_a = 32'hAAAA_0000;
    #2;
    check("R2", result, wr_en, 32'h1234_5678, 1'b1);
    @(negedge clk);
    check("R2", result, wr_en, 32'h0, 1'b0);
  endtask

  task automatic t_equality;
    cmp("R3", 4'd0, 32'h8000_0001, 32'h8000_0001);
    cmp("R3", 4'd0, 32'h8000_0001, 32'h0000_0001);
    cmp("R3", 4'd1, 32'h8000_0001, 32'h0000_0001);
    cmp("R3", 4'd1, 32'h7, 32'h7);
  endtask

  task automatic t_signed;
    logic [31:0] pa [3] = '{32'hFFFF_FFFF, 32'h0000_0001, 32'h8000_0000};
    logic [31:0] pb [3] = '{32'h0000_0001, 32'hFFFF_FFFF, 32'h8000_0000};
    for (int c = 0; c < 4; c++)
      for (int i = 0; i < 3; i++)
        cmp("R4", 4'(2 + 2*c), pa[i], pb[i]);
  endtask

  task automatic t_unsigned;
    logic [31:0] pa [3] = '{32'hFFFF_FFFF, 32'h0000_0001, 32'h7FFF_FFFF};
    logic [31:0] pb [3] = '{32'h0000_0001, 32'hFFFF_FFFF, 32'h7FFF_FFFF};
    for (int c = 0; c < 4; c++)
      for (int i = 0; i < 3; i++)
        cmp("R5", 4'(3 + 2*c), pa[i], pb[i]);
  endtask

  task automatic t_immediate;
    // src_b differs from the immediate, so a wrong mux shows
    apply("R6", 4'd0, 32'hFFFF_8000, 32'h0, 16'h8000, 1'b1, 32'h0, 32'd1, 1'b1);
    apply("R6", 4'd2, 32'hFFFF_FFFE, 32'h0, 16'hFFFF, 1'b1, 32'h0,
          {31'b0, rel(4'd2, 32'hFFFF_FFFE, sext(16'hFFFF))}, 1'b1);
    apply("R6", 4'd3, 32'h0000_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 1'b1, 32'h0, 32'd1, 1'b1);
    apply("R6", 4'd0, 32'h0000_1234, 32'h0000_1234, 16'h0034, 1'b1, 32'h0, 32'd0, 1'b1);
  endtask

  task automatic t_movz;
    apply("R7", 4'd10, 32'hCAFE_0001, 32'h0, 16'h0, 1'b0, 32'h1111_1111, 32'hCAFE_0001, 1'b1);
    apply("R7", 4'd10, 32'hCAFE_0002, 32'h8000_0000, 16'h0, 1'b0, 32'h2222_2222, 32'h2222_2222, 1'b0);
  endtask

  task automatic t_movn;
    apply("R8", 4'd11, 32'hBEEF_0001, 32'h0000_0001, 16'h0, 1'b0, 32'h3333_3333, 32'hBEEF_0001, 1'b1);
    apply("R8", 4'd11, 32'hBEEF_0002, 32'h0, 16'h0, 1'b0, 32'h4444_4444, 32'h4444_4444, 1'b0);
  endtask

  task automatic t_compare_writes;
    for (int o = 0; o < 10; o++)
      apply("R9", 4'(o), 32'h5, 32'h9, 16'h0, 1'b0, 32'h5555_5555,
            {31'b0, rel(4'(o), 32'h5, 32'h9)}, 1'b1);
  endtask

  task automatic t_undefined;
    for (int o = 12; o < 16; o++)
      apply("R10", 4'(o), 32'h6, 32'h0, 16'h0, 1'b0, 32'h0BAD_0000 + o, 32'h0BAD_0000 + o, 1'b0);
  endtask

  task automatic t_imm_on_move;
    apply("R11", 4'd10, 32'h7777_0000, 32'h5, 16'h0000, 1'b1, 32'h9999_9999, 32'h9999_9999, 1'b0);
    apply("R11", 4'd11, 32'h7777_0001, 32'h0, 16'h0001, 1'b1, 32'h8888_8888, 32'h8888_8888, 1'b0);
    apply("R11", 4'd10, 32'h7777_0002, 32'h0, 16'hFFFF, 1'b1, 32'h8888_8888, 32'h7777_0002, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", result, wr_en, 32'h0, 1'b0);
    rst = 1'b0;
    t_reset();
    t_latency();
    t_equality();
    t_signed();
    t_unsigned();
    t_immediate();
    t_movz();
    t_movn();
    t_compare_writes();
    t_undefined();
    t_imm_on_move();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: result=%h wr_en=%b expected run to finish", result, wr_en);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule